// File: doc/BRIEF.md
# ALU with Status Flag Register

This block is an 8-bit arithmetic and logic unit with the status register that it updates. Each clock cycle in which the enable is high, it applies the operation selected by a 4-bit function code to two operands. The result is captured in an output register. Each status flag has its own update rule: an operation writes only the flags defined for it, and the other flags keep their stored values. The stored carry feeds the carry-in and borrow-in of the extended add and subtract operations.

The compare operation writes no result. It sets separate unsigned Equal (Zero), Greater and Less flags. The input-ready flag in the status byte is not an ALU flag. It is a registered copy of a signal from the input-port logic, so no ALU operation can change it. Operand selection and write-back of the result to a register file are handled outside this block.

Top module: `aluflag_unit`

## Requirements
- R1: While `rst` is high on a clock edge, `result` becomes 0x00 and `status` becomes 0x00.
- R2: With `en` high, op 0x4 (add) and op 0x5 (add with carry, adding stored `status[7]`) produce the 8-bit sum in `result`. They set C (`status[7]`) to the unsigned carry out, V (`status[6]`) to signed overflow, Z (`status[5]`) when the result is zero, and N (`status[4]`) to result bit 7. G and L are unchanged.
- R3: With `en` high, op 0x6 (subtract) and op 0x7 (subtract with borrow, also subtracting stored `status[7]`) produce the 8-bit difference. C is set when an unsigned borrow occurs, V to signed overflow, and Z and N from the result. G and L are unchanged.
- R4: With `en` high, op 0x8 (AND), op 0x9 (OR) and op 0xA (XOR) produce the bitwise result and update only Z and N. C, V, G and L keep their values.
- R5: With `en` high, op 0xB shifts operand `a` right by one with 0 entering bit 7. C receives the bit shifted out of bit 0, and Z and N are set from the result. V, G and L keep their values.
- R6: With `en` high, op 0xC (compare) leaves `result` unchanged. It sets Z (`status[5]`) when a equals b, G (`status[3]`) when a is greater than b, and L (`status[2]`) when a is less than b, all unsigned. C, V and N keep their values.
- R7: On every clock edge outside reset, `status[1]` takes the value of `in_flag`, regardless of `en` and `op`.
- R8: With `en` low, `result` and `status[7:2]` keep their values.
- R9: With `en` high and an unassigned op code (0x0 to 0x3, 0xD to 0xF), `result` and `status[7:2]` keep their values.
- R10: `status[0]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Executes the selected operation on this edge |
| op | input | 4 | Function code |
| a | input | 8 | First operand (shift source, compare left side) |
| b | input | 8 | Second operand |
| in_flag | input | 1 | Input-ready indication from the input-port logic |
| result | output | 8 | Registered ALU result |
| status | output | 8 | Registered status byte {C,V,Z,N,G,L,I,0} |

## Verification
The assertions check the following on every cycle:
- the input flag tracks `in_flag` and bit 0 stays clear;
- an idle or unassigned-code cycle freezes the result and the ALU flags;
- the logic operations leave C, V, G and L untouched;
- the shift leaves V, G and L untouched;
- a compare leaves the result alone and raises exactly one of Z, G and L;
- whenever an operation writes a result, Z and N agree with that result.

Only the bench's scenarios can show that the arithmetic values are correct. This covers:
- carry and borrow out;
- signed overflow at the 0x7F/0x80 boundary;
- the use of the stored carry as carry-in and as borrow-in;
- the bit shifted out by the shift.

// File: rtl/aluflag_pkg.sv
package aluflag_pkg;

  // Function codes
  localparam logic [3:0] OP_ADD = 4'h4;
  localparam logic [3:0] OP_ADC = 4'h5;
  localparam logic [3:0] OP_SUB = 4'h6;
  localparam logic [3:0] OP_SBB = 4'h7;
  localparam logic [3:0] OP_AND = 4'h8;
  localparam logic [3:0] OP_OR  = 4'h9;
  localparam logic [3:0] OP_XOR = 4'hA;
  localparam logic [3:0] OP_SHR = 4'hB;
  localparam logic [3:0] OP_CMP = 4'hC;

  // Status byte; field order gives bit 7 down to bit 0
  typedef struct packed {
    logic c;    // carry / borrow
    logic v;    // signed overflow
    logic z;    // zero / equal
    logic n;    // negative
    logic g;    // greater (unsigned compare)
    logic l;    // less (unsigned compare)
    logic i;    // input ready, not an ALU flag
    logic rsv;  // always zero
  } status_t;

  localparam int STATUS_W = $bits(status_t);

  // Flags an op may write, as a status-byte mask
  function automatic logic [STATUS_W-1:0] op_flag_mask(input logic [3:0] op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: op_flag_mask = 8'b1111_0000;
      OP_AND, OP_OR, OP_XOR:          op_flag_mask = 8'b0011_0000;
      OP_SHR:                         op_flag_mask = 8'b1011_0000;
      OP_CMP:                         op_flag_mask = 8'b0010_1100;
      default:                        op_flag_mask = 8'b0000_0000;
    endcase
  endfunction

  // Whether an op writes the result register
  function automatic logic op_writes_result(input logic [3:0] op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB,
      OP_AND, OP_OR, OP_XOR, OP_SHR: op_writes_result = 1'b1;
      default:                       op_writes_result = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/aluflag_core.sv
module aluflag_core
  import aluflag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res,
  output status_t           flags
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   ext_sum;
  logic [DATA_W:0]   ext_dif;
  logic              cin_add;
  logic              cin_sub;
  logic              ovf_add;
  logic              ovf_sub;

  assign cin_add = (op == OP_ADC) ? carry_in : 1'b0;
  assign cin_sub = (op == OP_SBB) ? carry_in : 1'b0;

  // One extra bit catches the carry, or the borrow as a wrap
  assign ext_sum = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin_add};
  assign ext_dif = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin_sub};

  assign ovf_add = (a[MSB] == b[MSB]) && (ext_sum[MSB] != a[MSB]);
  assign ovf_sub = (a[MSB] != b[MSB]) && (ext_dif[MSB] != a[MSB]);

  always_comb begin
    res   = '0;
    flags = '0;
    case (op)
      OP_ADD, OP_ADC: begin
        res     = ext_sum[MSB:0];
        flags.c = ext_sum[DATA_W];
        flags.v = ovf_add;
      end
      OP_SUB, OP_SBB: begin
        res     = ext_dif[MSB:0];
        flags.c = ext_dif[DATA_W];
        flags.v = ovf_sub;
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_SHR: begin
        res     = {1'b0, a[MSB:1]};
        flags.c = a[0];
      end
      default: res = '0;
    endcase

    if (op == OP_CMP) begin
      flags.z = (a == b);
      flags.g = (a > b);
      flags.l = (a < b);
    end else begin
      flags.z = (res == '0);
      flags.n = res[MSB];
    end
  end

endmodule

// File: rtl/aluflag_decode.sv
module aluflag_decode
  import aluflag_pkg::*;
(
  input  logic [3:0]          op,
  input  logic                en,
  output logic [STATUS_W-1:0] flag_we,
  output logic                res_we
);

  assign flag_we = en ? op_flag_mask(op) : '0;
  assign res_we  = en & op_writes_result(op);

endmodule

// File: rtl/aluflag_regs.sv
module aluflag_regs
  import aluflag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                res_we,
  input  logic [STATUS_W-1:0] flag_we,
  input  logic [DATA_W-1:0]   res_next,
  input  status_t             flag_next,
  input  logic                in_flag,
  output logic [DATA_W-1:0]   result_q,
  output status_t             status_q
);

  localparam int ALU_LO = 2;  // lowest bit written by the ALU

  logic [STATUS_W-1:0] st_bits;
  logic [STATUS_W-1:0] nx_bits;

  assign st_bits = status_q;
  assign nx_bits = flag_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
    end else if (res_we) begin
      result_q <= res_next;
    end
  end

  // One enable per ALU flag bit
  for (genvar k = ALU_LO; k < STATUS_W; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        status_q[k] <= 1'b0;
      end else if (flag_we[k]) begin
        status_q[k] <= nx_bits[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q.i <= 1'b0;
    end else begin
      status_q.i <= in_flag;
    end
  end

  always_ff @(posedge clk) begin
    status_q.rsv <= 1'b0;
  end

  logic unused_bits;
  assign unused_bits = ^{st_bits[ALU_LO-1:0], nx_bits[ALU_LO-1:0], flag_we[ALU_LO-1:0]};

endmodule

// File: rtl/aluflag_unit.sv
module aluflag_unit
  import aluflag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              in_flag,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        status
);

  logic [DATA_W-1:0]   core_res;
  status_t             core_flags;
  logic [STATUS_W-1:0] flag_we;
  logic                res_we;
  status_t             st_q;

  aluflag_core #(.DATA_W(DATA_W)) u_core (
    .op       (op),
    .a        (a),
    .b        (b),
    .carry_in (st_q.c),
    .res      (core_res),
    .flags    (core_flags)
  );

  aluflag_decode u_dec (
    .op      (op),
    .en      (en),
    .flag_we (flag_we),
    .res_we  (res_we)
  );

  aluflag_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .res_we    (res_we),
    .flag_we   (flag_we),
    .res_next  (core_res),
    .flag_next (core_flags),
    .in_flag   (in_flag),
    .result_q  (result),
    .status_q  (st_q)
  );

  assign status = st_q;

endmodule

// File: rtl/aluflag_chk.sv
module aluflag_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [3:0]        op,
  input logic              in_flag,
  input logic [DATA_W-1:0] result,
  input logic [7:0]        status
);

  logic is_logic, is_shr, is_cmp, is_none, is_wr;
  assign is_logic = en && (op == 4'h8 || op == 4'h9 || op == 4'hA);
  assign is_shr   = en && (op == 4'hB);
  assign is_cmp   = en && (op == 4'hC);
  assign is_none  = !en || op < 4'h4 || op > 4'hC;
  assign is_wr    = en && op >= 4'h4 && op <= 4'hB;

  // R7
  a_r7_input_flag: assert property (@(posedge clk) disable iff (rst)
    !rst |=> status[1] == $past(in_flag));

  // R10
  a_r10_bit0_clear: assert property (@(posedge clk) disable iff (rst)
    !rst |=> status[0] == 1'b0);

  // R8, R9
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    is_none |=> $stable(result) && $stable(status[7:2]));

  // R4
  a_r4_logic_keep: assert property (@(posedge clk) disable iff (rst)
    is_logic |=> $stable(status[7:6]) && $stable(status[3:2]));

  // R5
  a_r5_shr_keep: assert property (@(posedge clk) disable iff (rst)
    is_shr |=> $stable(status[6]) && $stable(status[3:2]));

  // R6
  a_r6_cmp_onehot: assert property (@(posedge clk) disable iff (rst)
    is_cmp |=> $countones({status[5], status[3], status[2]}) == 1);

  a_r6_cmp_keep: assert property (@(posedge clk) disable iff (rst)
    is_cmp |=> $stable(result) && $stable(status[7:6]) && $stable(status[4]));

  // R2, R3
  a_r2_zn_track: assert property (@(posedge clk) disable iff (rst)
    is_wr |=> status[5] == (result == '0) && status[4] == result[DATA_W-1]);

endmodule

bind aluflag_unit aluflag_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .op      (op),
  .in_flag (in_flag),
  .result  (result),
  .status  (status)
);

// File: tb/aluflag_unit_bench.sv
`timescale 1ns/1ps
module aluflag_unit_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [3:0] op = 4'h0;
  logic [7:0] a = 8'h00;
  logic [7:0] b = 8'h00;
  logic       in_flag = 1'b0;
  logic [7:0] result;
  logic [7:0] status;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] exp_res = 8'h00;
  logic [7:0] exp_st  = 8'h00;

  always #2.5 clk = ~clk;

  aluflag_unit u_aluflag_unit (
    .clk(clk), .rst(rst), .en(en), .op(op), .a(a), .b(b),
    .in_flag(in_flag), .result(result), .status(status)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic string tag_of(input logic e, input logic [3:0] o);
    if (!e) return "R8";
    case (o)
      4'h4, 4'h5:       return "R2";
      4'h6, 4'h7:       return "R3";
      4'h8, 4'h9, 4'hA: return "R4";
      4'hB:             return "R5";
      4'hC:             return "R6";
      default:          return "R9";
    endcase
  endfunction

  // Reference model from the requirements: returns {result, status[7:2] with low bits 0}
  function automatic logic [15:0] ref_step(input logic e, input logic [3:0] o,
      input logic [7:0] x, input logic [7:0] y, input logic [7:0] st, input logic [7:0] r);
    logic [7:0] nr = r;
    logic [7:0] ns = st;
    int s;
    if (e) begin
      case (o)
        4'h4, 4'h5: begin
          s = int'(x) + int'(y) + ((o == 4'h5) ? int'(st[7]) : 0);
          nr = s[7:0];
          ns[7] = (s > 255);
          ns[6] = (x[7] == y[7]) && (nr[7] != x[7]);
        end
        4'h6, 4'h7: begin
          s = int'(x) - int'(y) - ((o == 4'h7) ? int'(st[7]) : 0);
          nr = s[7:0];
          ns[7] = (s < 0);
          ns[6] = (x[7] != y[7]) && (nr[7] != x[7]);
        end
        4'h8: nr = x & y;
        4'h9: nr = x | y;
        4'hA: nr = x ^ y;
        4'hB: begin
          nr = x >> 1;
          ns[7] = x[0];
        end
        4'hC: begin
          ns[5] = (x == y);
          ns[3] = (x > y);
          ns[2] = (x < y);
        end
        default: ;
      endcase
      if (o >= 4'h4 && o <= 4'hB) begin
        ns[5] = (nr == 8'h00);
        ns[4] = nr[7];
      end
    end
    return {nr, ns[7:2], 2'b00};
  endfunction

  task automatic step(input logic e, input logic [3:0] o, input logic [7:0] x,
                      input logic [7:0] y, input logic inf);
    logic [15:0] m;
    string t;
    @(negedge clk);
    en = e; op = o; a = x; b = y; in_flag = inf;
    m = ref_step(e, o, x, y, exp_st, exp_res);
    exp_res = m[15:8];
    exp_st  = {m[7:2], inf, 1'b0};
    t = tag_of(e, o);
    @(posedge clk);
    #1;
    check({t, " result"}, result, exp_res);
    check({t, " flags"}, {status[7:2], 2'b00}, {exp_st[7:2], 2'b00});
    check("R7 input flag", {7'd0, status[1]}, {7'd0, exp_st[1]});
    check("R10 bit0", {7'd0, status[0]}, 8'h00);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    in_flag = 1'b1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state, in_flag high must not leak in during reset
    check("R1 result", result, 8'h00);
    check("R1 status", status, 8'h00);
    @(negedge clk);
    rst = 1'b0; in_flag = 1'b0;

    // R2 directed
    step(1, 4'h4, 8'h7F, 8'h01, 0);  // 80: V=1 N=1
    step(1, 4'h4, 8'hFF, 8'h01, 1);  // 00: C=1 Z=1
    step(1, 4'h5, 8'h10, 8'h20, 0);  // 31 uses stored C
    step(1, 4'h4, 8'h80, 8'h80, 0);  // 00: C=1 V=1 Z=1
    // R3 directed
    step(1, 4'h6, 8'h00, 8'h01, 1);  // FF: borrow
    step(1, 4'h7, 8'h05, 8'h03, 0);  // 01 uses stored borrow
    step(1, 4'h6, 8'h80, 8'h01, 0);  // 7F: V=1
    step(1, 4'h7, 8'h00, 8'h00, 0);  // 00, no borrow held
    // R6 directed
    step(1, 4'hC, 8'h42, 8'h42, 0);
    step(1, 4'hC, 8'hF0, 8'h0F, 1);  // unsigned greater
    step(1, 4'hC, 8'h01, 8'hFF, 0);
    // R4 directed, G/L/C/V must hold
    step(1, 4'h8, 8'hF0, 8'h0F, 0);
    step(1, 4'h9, 8'h80, 8'h01, 0);
    step(1, 4'hA, 8'hAA, 8'hAA, 1);
    // R5 directed
    step(1, 4'hB, 8'h01, 8'h00, 0);
    step(1, 4'hB, 8'hFE, 8'h00, 0);
    // R8 / R9: no effect
    step(0, 4'h4, 8'hFF, 8'hFF, 1);
    step(1, 4'h2, 8'h12, 8'h34, 0);
    step(1, 4'hF, 8'h00, 8'h00, 1);
    step(1, 4'h0, 8'h55, 8'h55, 0);

    // Constrained random: mostly enabled, mostly defined codes
    for (int k = 0; k < 600; k++) begin
      logic e;
      logic [3:0] o;
      e = ($urandom % 8) != 0;
      o = (($urandom % 10) == 0) ? 4'($urandom) : 4'(4 + ($urandom % 9));
      step(e, o, 8'($urandom), 8'($urandom), 1'($urandom));
    end

    finish_run();
  end

endmodule